// File: doc/BRIEF.md
# SIMM Bank Configuration Register File

This block is the byte-wide I/O register front end of a memory controller that serves six SIMM sockets. Each socket is strapped at board level as empty, 8 MB or 32 MB. Software reads two read-only registers to learn which sockets hold a module and which modules are large. It then programs eight 5-bit end-address registers, in units of 8 MB, that tell a downstream bank decoder where each bank stops.

The end-address registers are asymmetric. A write carries its own 3-bit register index in the top of the data byte. A read goes through a hidden pointer that steps forward after every read and wraps after the last register. Reading the presence register returns that pointer to register 0, so software can walk the whole table from a known start. A fixed parity status register always reports that no parity error was found. The stored end addresses and the per-socket size and presence summaries are driven out as plain vectors for the bank decoder.

Read data is registered. It appears on `bus_rdata` in the cycle after the read strobe and is held until the next read.

Top module: `simm_bank_regs`

## Requirements
- R1: A synchronous reset clears all eight end-address registers, the read pointer and `bus_rdata` to zero.
- R2: A read at 0x803 returns bit n = 1 exactly when socket n is strapped 32 MB; bits 7:6 read 0. Strap code per socket: 2'b00 empty, 2'b01 8 MB, 2'b10 32 MB, 2'b11 reserved and treated as empty.
- R3: A read at 0x804 returns bit n = 0 exactly when socket n is strapped 8 MB or 32 MB, and 1 otherwise; bits 7:6 always read 1.
- R4: Every read at 0x804 sets the end-address read pointer back to register 0.
- R5: A write at 0x820 stores data bits [4:0] into the end-address register selected by data bits [7:5]. The new value shows on `end_addr_vec` bits [5*i+4:5*i] for register i in the next cycle.
- R6: A read at 0x820 returns the register selected by the read pointer in bits [4:0], with bits 7:5 at 0. The pointer then advances by one and wraps from 7 to 0.
- R7: A read at 0x841 always returns 0x01.
- R8: A read at any other address returns 0x00 and leaves the read pointer unchanged.
- R9: A write to 0x803, 0x804, 0x841 or any unmapped address changes no end-address register and does not move the read pointer.
- R10: `bus_rdata` changes only in the cycle after a read strobe and otherwise holds its last value.
- R11: `big_mask` bit n is 1 when socket n is strapped 32 MB and `populated_mask` bit n is 1 when socket n is strapped 8 MB or 32 MB. Both follow the straps with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_size | input | 12 | Per-socket size strap, 2 bits per socket, socket n at bits [2n+1:2n] |
| bus_addr | input | 12 | I/O address |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| end_addr_vec | output | 40 | Eight 5-bit end addresses, register i at bits [5i+4:5i] |
| big_mask | output | 6 | Per-socket 32 MB flag |
| populated_mask | output | 6 | Per-socket populated flag |

## Verification
The assertions check, in every cycle, the things that follow from one access: the fixed bits of the ID, presence and parity reads, the captured value of an end-address write, that the register table stays still when no end-address write occurs, that read data holds between reads, and that a large module is never reported as absent. The pointer walk has to be shown by the bench's scenarios. That covers the wrap after eight reads, the return to register 0 after a presence read, and the fact that reads of unmapped or other addresses leave the pointer where it was. The bench also checks the reset state and the full read-back contents against its own model.

// File: rtl/simm_cfg_pkg.sv
package simm_cfg_pkg;

    // Per-socket strap codes
    localparam logic [1:0] STRAP_EMPTY = 2'b00;
    localparam logic [1:0] STRAP_8MB   = 2'b01;
    localparam logic [1:0] STRAP_32MB  = 2'b10;

    // Which register a bus access hits
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_ID   = 3'd1,
        SEL_PRES = 3'd2,
        SEL_END  = 3'd3,
        SEL_PAR  = 3'd4
    } port_sel_e;

endpackage

// File: rtl/simm_strap_decode.sv
module simm_strap_decode #(
    parameter int NUM_SOCKETS = 6
) (
    input  logic [2*NUM_SOCKETS-1:0] strap_size,
    output logic [NUM_SOCKETS-1:0]   big_mask,
    output logic [NUM_SOCKETS-1:0]   populated_mask
);
    import simm_cfg_pkg::*;

    for (genvar s = 0; s < NUM_SOCKETS; s++) begin : g_sock
        logic [1:0] code;
        assign code              = strap_size[2*s +: 2];
        assign big_mask[s]       = (code == STRAP_32MB);
        assign populated_mask[s] = (code == STRAP_32MB) || (code == STRAP_8MB);
    end
endmodule

// File: rtl/simm_port_decode.sv
module simm_port_decode #(
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] ID_ADDR   = 12'h803,
    parameter logic [11:0] PRES_ADDR = 12'h804,
    parameter logic [11:0] END_ADDR  = 12'h820,
    parameter logic [11:0] PAR_ADDR  = 12'h841
) (
    input  logic [ADDR_W-1:0]       bus_addr,
    output simm_cfg_pkg::port_sel_e sel
);
    import simm_cfg_pkg::*;

    localparam int NUM_PORTS = 4;

    logic [NUM_PORTS-1:0]   hit;
    logic [ADDR_W-1:0]      port_addr [NUM_PORTS];
    port_sel_e              port_code [NUM_PORTS];

    assign port_addr[0] = ADDR_W'(ID_ADDR);
    assign port_addr[1] = ADDR_W'(PRES_ADDR);
    assign port_addr[2] = ADDR_W'(END_ADDR);
    assign port_addr[3] = ADDR_W'(PAR_ADDR);
    assign port_code[0] = SEL_ID;
    assign port_code[1] = SEL_PRES;
    assign port_code[2] = SEL_END;
    assign port_code[3] = SEL_PAR;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
        assign hit[p] = (bus_addr == port_addr[p]);
    end

    always_comb begin
        sel = SEL_NONE;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (hit[p]) sel = port_code[p];
        end
    end
endmodule

// File: rtl/simm_end_regfile.sv
module simm_end_regfile #(
    parameter int NUM_ENDS = 8,
    parameter int END_W    = 5,
    localparam int IDX_W   = $clog2(NUM_ENDS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [END_W-1:0]          wr_val,
    input  logic                      ptr_adv,
    input  logic                      ptr_clr,
    output logic [NUM_ENDS*END_W-1:0] end_flat,
    output logic [END_W-1:0]          ptr_val
);
    typedef struct packed {
        logic [NUM_ENDS-1:0][END_W-1:0] ends;
        logic [IDX_W-1:0]               ptr;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (32'(wr_idx) < NUM_ENDS)) begin
            st_d.ends[wr_idx] = wr_val;
        end
        if (ptr_clr) begin
            st_d.ptr = '0;
        end else if (ptr_adv) begin
            if (32'(st_q.ptr) == NUM_ENDS - 1) st_d.ptr = '0;
            else                               st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign end_flat = st_q.ends;
    assign ptr_val  = st_q.ends[st_q.ptr];
endmodule

// File: rtl/simm_rdata_reg.sv
module simm_rdata_reg #(
    parameter int DATA_W      = 8,
    parameter int NUM_SOCKETS = 6,
    parameter int END_W       = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd,
    input  simm_cfg_pkg::port_sel_e sel,
    input  logic [NUM_SOCKETS-1:0]  big_mask,
    input  logic [NUM_SOCKETS-1:0]  populated_mask,
    input  logic [END_W-1:0]        ptr_val,
    output logic [DATA_W-1:0]       rdata
);
    import simm_cfg_pkg::*;

    localparam logic [DATA_W-1:0] PAR_OK = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [DATA_W-1:0] id_byte, pres_byte, end_byte, mux_byte;

    always_comb begin
        id_byte   = '0;
        pres_byte = '1;
        end_byte  = '0;
        id_byte[NUM_SOCKETS-1:0]   = big_mask;
        pres_byte[NUM_SOCKETS-1:0] = ~populated_mask;
        end_byte[END_W-1:0]        = ptr_val;
    end

    always_comb begin
        unique case (sel)
            SEL_ID:   mux_byte = id_byte;
            SEL_PRES: mux_byte = pres_byte;
            SEL_END:  mux_byte = end_byte;
            SEL_PAR:  mux_byte = PAR_OK;
            default:  mux_byte = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (rd) st_d.data = mux_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rdata = st_q.data;
endmodule

// File: rtl/simm_bank_regs.sv
module simm_bank_regs #(
    parameter int          NUM_SOCKETS = 6,
    parameter int          NUM_ENDS    = 8,
    parameter int          END_W       = 5,
    parameter int          ADDR_W      = 12,
    parameter int          DATA_W      = 8,
    parameter logic [11:0] ID_ADDR     = 12'h803,
    parameter logic [11:0] PRES_ADDR   = 12'h804,
    parameter logic [11:0] END_ADDR    = 12'h820,
    parameter logic [11:0] PAR_ADDR    = 12'h841
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [2*NUM_SOCKETS-1:0]  strap_size,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_rd,
    input  logic                      bus_wr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [NUM_ENDS*END_W-1:0] end_addr_vec,
    output logic [NUM_SOCKETS-1:0]    big_mask,
    output logic [NUM_SOCKETS-1:0]    populated_mask
);
    import simm_cfg_pkg::*;

    localparam int IDX_W = $clog2(NUM_ENDS);
    localparam int IDX_LSB = DATA_W - IDX_W;

    port_sel_e        sel;
    logic             end_wr, ptr_adv, ptr_clr;
    logic [END_W-1:0] ptr_val;

    simm_strap_decode #(.NUM_SOCKETS(NUM_SOCKETS)) u_strap (
        .strap_size     (strap_size),
        .big_mask       (big_mask),
        .populated_mask (populated_mask)
    );

    simm_port_decode #(
        .ADDR_W(ADDR_W), .ID_ADDR(ID_ADDR), .PRES_ADDR(PRES_ADDR),
        .END_ADDR(END_ADDR), .PAR_ADDR(PAR_ADDR)
    ) u_dec (
        .bus_addr (bus_addr),
        .sel      (sel)
    );

    assign end_wr  = bus_wr && (sel == SEL_END);
    assign ptr_adv = bus_rd && (sel == SEL_END);
    assign ptr_clr = bus_rd && (sel == SEL_PRES);

    simm_end_regfile #(.NUM_ENDS(NUM_ENDS), .END_W(END_W)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (end_wr),
        .wr_idx   (bus_wdata[IDX_LSB +: IDX_W]),
        .wr_val   (bus_wdata[END_W-1:0]),
        .ptr_adv  (ptr_adv),
        .ptr_clr  (ptr_clr),
        .end_flat (end_addr_vec),
        .ptr_val  (ptr_val)
    );

    simm_rdata_reg #(
        .DATA_W(DATA_W), .NUM_SOCKETS(NUM_SOCKETS), .END_W(END_W)
    ) u_rd (
        .clk            (clk),
        .rst            (rst),
        .rd             (bus_rd),
        .sel            (sel),
        .big_mask       (big_mask),
        .populated_mask (populated_mask),
        .ptr_val        (ptr_val),
        .rdata          (bus_rdata)
    );
endmodule

// File: rtl/simm_bank_regs_chk.sv
module simm_bank_regs_chk #(
    parameter int          NUM_SOCKETS = 6,
    parameter int          NUM_ENDS    = 8,
    parameter int          END_W       = 5,
    parameter int          ADDR_W      = 12,
    parameter int          DATA_W      = 8,
    parameter logic [11:0] ID_ADDR     = 12'h803,
    parameter logic [11:0] PRES_ADDR   = 12'h804,
    parameter logic [11:0] END_ADDR    = 12'h820,
    parameter logic [11:0] PAR_ADDR    = 12'h841
) (
    input logic                      clk,
    input logic                      rst,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      bus_rd,
    input logic                      bus_wr,
    input logic [DATA_W-1:0]         bus_wdata,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic [NUM_ENDS*END_W-1:0] end_addr_vec,
    input logic [NUM_SOCKETS-1:0]    big_mask,
    input logic [NUM_SOCKETS-1:0]    populated_mask
);
    localparam int IDX_W   = $clog2(NUM_ENDS);
    localparam int IDX_LSB = DATA_W - IDX_W;

    logic             end_wr_hit;
    logic             wr_seen_q;
    logic [IDX_W-1:0] wr_idx_q;
    logic [END_W-1:0] wr_val_q;
    logic [END_W-1:0] wr_slice;

    assign end_wr_hit = bus_wr && (bus_addr == ADDR_W'(END_ADDR));

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_seen_q <= 1'b0;
            wr_idx_q  <= '0;
            wr_val_q  <= '0;
        end else begin
            wr_seen_q <= end_wr_hit;
            wr_idx_q  <= bus_wdata[IDX_LSB +: IDX_W];
            wr_val_q  <= bus_wdata[END_W-1:0];
        end
    end

    assign wr_slice = end_addr_vec[32'(wr_idx_q)*END_W +: END_W];

    assert_id_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(ID_ADDR)) |=>
            (bus_rdata[DATA_W-1:NUM_SOCKETS] == '0));

    assert_pres_upper_one_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(PRES_ADDR)) |=>
            (bus_rdata[DATA_W-1:NUM_SOCKETS] == '1));

    assert_end_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
        wr_seen_q |-> (wr_slice == wr_val_q));

    assert_end_read_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(END_ADDR)) |=>
            (bus_rdata[DATA_W-1:END_W] == '0));

    assert_parity_ok_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(PAR_ADDR)) |=> (bus_rdata == DATA_W'(1)));

    assert_no_stray_write_R9: assert property (@(posedge clk) disable iff (rst)
        !end_wr_hit |=> $stable(end_addr_vec));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    assert_big_is_present_R11: assert property (@(posedge clk) disable iff (rst)
        ((big_mask & ~populated_mask) == '0));
endmodule

bind simm_bank_regs simm_bank_regs_chk #(
    .NUM_SOCKETS(NUM_SOCKETS), .NUM_ENDS(NUM_ENDS), .END_W(END_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_ADDR(ID_ADDR),
    .PRES_ADDR(PRES_ADDR), .END_ADDR(END_ADDR), .PAR_ADDR(PAR_ADDR)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_rd         (bus_rd),
    .bus_wr         (bus_wr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .end_addr_vec   (end_addr_vec),
    .big_mask       (big_mask),
    .populated_mask (populated_mask)
);

// File: tb/test_simm_bank_regs.sv
`timescale 1ns/1ps
module test_simm_bank_regs;
    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] strap_size;
    logic [11:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [39:0] end_addr_vec;
    logic [5:0]  big_mask, populated_mask;

    int n_chk = 0;
    int n_bad = 0;
    logic [4:0] m_end [8];
    int         m_ptr;

    always #5 clk = ~clk;

    simm_bank_regs i_simm_bank_regs (
        .clk(clk), .rst(rst), .strap_size(strap_size),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .end_addr_vec(end_addr_vec), .big_mask(big_mask),
        .populated_mask(populated_mask)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] f_big(logic [11:0] s);
        logic [5:0] r;
        for (int i = 0; i < 6; i++) r[i] = (s[2*i +: 2] == 2'b10);
        return r;
    endfunction

    function automatic logic [5:0] f_pop(logic [11:0] s);
        logic [5:0] r;
        for (int i = 0; i < 6; i++) r[i] = (s[2*i +: 2] == 2'b10) || (s[2*i +: 2] == 2'b01);
        return r;
    endfunction

    function automatic logic [39:0] f_vec();
        logic [39:0] v;
        for (int i = 0; i < 8; i++) v[5*i +: 5] = m_end[i];
        return v;
    endfunction

    // Expected read data plus model side effects
    function automatic logic [7:0] model_read(logic [11:0] a);
        logic [7:0] r;
        case (a)
            12'h803: r = {2'b00, f_big(strap_size)};
            12'h804: begin r = {2'b11, ~f_pop(strap_size)}; m_ptr = 0; end
            12'h820: begin r = {3'b000, m_end[m_ptr]}; m_ptr = (m_ptr + 1) % 8; end
            12'h841: r = 8'h01;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    function automatic string tag_of(logic [11:0] a);
        case (a)
            12'h803: return "R2";
            12'h804: return "R3";
            12'h820: return "R6";
            12'h841: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic do_read(logic [11:0] a, string tag);
        logic [7:0] e;
        e = model_read(a);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        check(tag, bus_rdata, e);
        @(negedge clk);
        check({tag, " R10 hold"}, bus_rdata, e);
    endtask

    task automatic do_write(logic [11:0] a, logic [7:0] d, string tag);
        if (a == 12'h820) m_end[d[7:5]] = d[4:0];
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        check(tag, end_addr_vec, f_vec());
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(150000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [11:0] addrs [6];
        void'($urandom(32'h5eed_c0de));
        addrs = '{12'h803, 12'h804, 12'h820, 12'h841, 12'h821, 12'h000};
        for (int i = 0; i < 8; i++) m_end[i] = '0;
        m_ptr = 0;
        rst = 1'b1; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        strap_size = {2'b00, 2'b11, 2'b01, 2'b01, 2'b10, 2'b10};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 ends", end_addr_vec, 40'h0);
        do_read(12'h820, "R1 ptr/R6");
        // R11 straps
        check("R11 big", big_mask, 6'b000011);
        check("R11 pop", populated_mask, 6'b001111);
        strap_size = 12'b10_01_00_11_10_01;
        #1;
        check("R11 big2", big_mask, 6'b100010);
        check("R11 pop2", populated_mask, 6'b110011);
        do_read(12'h803, "R2");
        do_read(12'h804, "R3 R4");
        // R5 fill every register
        for (int i = 0; i < 8; i++) do_write(12'h820, {3'(i), 5'(3 * i + 4)}, "R5");
        // R6 walk with wrap
        for (int i = 0; i < 10; i++) do_read(12'h820, "R6 walk");
        // R4 clear mid-walk, then R8 reads don't move pointer
        do_read(12'h804, "R4");
        do_read(12'h820, "R4 first");
        do_read(12'h123, "R8");
        do_read(12'h841, "R7");
        do_read(12'h820, "R8 ptr kept");
        // R9 writes to read-only and unmapped addresses
        do_write(12'h803, 8'hFF, "R9 id");
        do_write(12'h804, 8'h1F, "R9 pres");
        do_write(12'h841, 8'hE7, "R9 par");
        do_write(12'h821, 8'h3A, "R9 unmapped");
        do_read(12'h820, "R9 ptr kept");
        // Random mix
        for (int k = 0; k < 600; k++) begin
            int op;
            logic [11:0] a;
            op = $urandom_range(0, 9);
            a = addrs[$urandom_range(0, 5)];
            if (op == 0) begin
                strap_size = 12'($urandom());
                #1;
                check("R11 rand big", big_mask, f_big(strap_size));
                check("R11 rand pop", populated_mask, f_pop(strap_size));
            end else if (op < 4) begin
                do_write(a, 8'($urandom()), (a == 12'h820) ? "R5 rand" : "R9 rand");
            end else begin
                do_read(a, tag_of(a));
            end
        end
        // R1 reset again after traffic
        rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 8; i++) m_end[i] = '0;
        m_ptr = 0;
        check("R1 ends again", end_addr_vec, 40'h0);
        check("R1 rdata again", bus_rdata, 8'h00);
        finish_run();
    end
endmodule